// File: doc/BRIEF.md
# Dual-Channel Pointer-Indexed Register File

This block is the host-side register interface of a two-channel serial controller. A host reaches each channel through a control port and a data port. Most registers take two steps. A control-port write with the channel's pointer at zero loads the pointer from the low nibble of the written value. The next control-port access, read or write, then reaches the selected register, and the pointer falls back to zero. The data port reaches the transmit and receive data slot directly, with no pointer step.

The block stores the write registers of both channels. It keeps one copy of the vector and master-interrupt registers for both channels. Slot 7 leads to one of two registers, chosen by a select bit in slot 15. Reset and phase-lock command bits are decoded into one-cycle strobes and are not stored. Read values come from status inputs driven by the serial engines, from stored registers, or from a mix of the two. After every accepted access the block is busy for a recovery interval, and it ignores any access made while busy.

Top module: `sio_regfile`

## Requirements
- R1: With a channel's pointer at zero, a control write loads the pointer from wdata[3:0]. The next control access on that channel reaches the register with that index, and the pointer then returns to zero. A control read at pointer zero returns the channel's line status. Index 1 returns the condition status and index 10 returns the clock status. Each channel has its own pointer.
- R2: A data-port write stores the byte in slot 8 of the channel's configuration and pulses that channel's bit of tx_load (bit 0 = A, bit 1 = B). A data-port read returns the channel's rx_byte. Neither one changes the pointer.
- R3: A control write at index 7 goes to the alternate option register (opt_a/opt_b) when bit 0 of the channel's slot 15 is set. When that bit is clear it goes to slot 7.
- R4: Slots 2 (vector) and 9 (master control) are single copies shared by both channels. A write from either channel shows in both cfg_a and cfg_b, and a read of index 2 on channel A returns the stored vector.
- R5: A read of index 3 on channel A returns irq_pend. On channel B it returns 0x00.
- R6: A read of index 2 on channel B returns vec_live and not the stored vector.
- R7: A write to index 9 stores only bits 5:0. Bits 7:6 are a reset command that pulses chan_rst: 01 resets channel A, 10 resets channel B, 11 resets everything. A channel reset clears that channel's stored slots, its option register and its pointer, and leaves the shared slots alone. 11 also clears the shared slots.
- R8: A write to index 14 stores only bits 4:0. A nonzero bits 7:5 pulses the channel's dpll_stb bit, with dpll_cmd set to that value.
- R9: When bit 6 of the channel's option register is set, reads of indices 4, 5, 9 and 11 return slots 4, 5, 3 and 10. When the bit is clear these reads return 0x00. Reads of 12, 13 and 15 always return those slots.
- R10: Every accepted access holds busy high for RECOV cycles, starting the next cycle. An access presented while busy is high is ignored.
- R11: After reset every slot, option register and pointer is zero, busy is low and rdata is 0x00.
- R12: Every control write at pointer zero pulses the channel's cmd_stb bit and presents the byte on cmd_val. A value whose low nibble is zero leaves the pointer at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_en | input | 1 | Access strobe, one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ch | input | 1 | Channel, 0 = A, 1 = B |
| acc_dp | input | 1 | 1 = data port, 0 = control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, updated the cycle after a read |
| busy | output | 1 | Recovery interval active |
| line_st | input | 2x8 | Line status per channel (index 1 = B) |
| cond_st | input | 2x8 | Condition status per channel |
| clk_st | input | 2x8 | Clock status per channel |
| rx_byte | input | 2x8 | Received byte per channel |
| vec_live | input | 8 | Vector with live status |
| irq_pend | input | 8 | Pending interrupt bits |
| cfg_a | output | 128 | Channel A slots, slot n at bits 8n+7:8n |
| cfg_b | output | 128 | Channel B slots |
| opt_a | output | 8 | Channel A alternate option register |
| opt_b | output | 8 | Channel B alternate option register |
| tx_load | output | 2 | Transmit byte written, per channel |
| cmd_stb | output | 2 | Command write at pointer zero, per channel |
| cmd_val | output | 8 | Byte of the last command write |
| chan_rst | output | 2 | Reset command pulse, per channel |
| dpll_stb | output | 2 | Phase-lock command pulse, per channel |
| dpll_cmd | output | 3 | Phase-lock command code |

## Verification
A pointer left non-zero by mistake sends the next control access to the wrong register. It shows at the ports on the following access, as a status read returning a stored slot or as a write landing in the wrong cfg field. A wrong slot-15 select bit or option bit shows the first time slot 7 is written or an extended index is read. Reset commands act on the edge that accepts the write, so a wrongly cleared or wrongly kept register shows in cfg_a, cfg_b or the option outputs one cycle after that edge. A busy counter that is off by one shows as a recovery window of the wrong length, or as an access that should have been dropped changing state.

// File: rtl/sio_regfile.sv
module sio_regfile #(
  parameter int RECOV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic             acc_ch,
  input  logic             acc_dp,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             busy,
  input  logic [1:0][7:0]  line_st,
  input  logic [1:0][7:0]  cond_st,
  input  logic [1:0][7:0]  clk_st,
  input  logic [1:0][7:0]  rx_byte,
  input  logic [7:0]       vec_live,
  input  logic [7:0]       irq_pend,
  output logic [127:0]     cfg_a,
  output logic [127:0]     cfg_b,
  output logic [7:0]       opt_a,
  output logic [7:0]       opt_b,
  output logic [1:0]       tx_load,
  output logic [1:0]       cmd_stb,
  output logic [7:0]       cmd_val,
  output logic [1:0]       chan_rst,
  output logic [1:0]       dpll_stb,
  output logic [2:0]       dpll_cmd
);
  localparam int CW = $clog2(RECOV + 1);

  logic [CW-1:0] cnt;
  logic [7:0]    wreg [2][16];
  logic [7:0]    opt  [2];
  logic [3:0]    ptr  [2];
  logic [7:0]    sh_vec, sh_mic;
  logic [7:0]    rd_mux;

  wire       go   = acc_en && (cnt == '0);
  wire [3:0] idx  = acc_dp ? 4'd8 : ptr[acc_ch];
  wire       ext  = opt[acc_ch][6];
  wire [1:0] rcmd = (go && acc_wr && !acc_dp && ptr[acc_ch] == 4'd9) ? wdata[7:6] : 2'b00;

  assign busy  = (cnt != '0);
  assign opt_a = opt[0];
  assign opt_b = opt[1];

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      if (i == 2) begin
        cfg_a[8*i +: 8] = sh_vec;
        cfg_b[8*i +: 8] = sh_vec;
      end else if (i == 9) begin
        cfg_a[8*i +: 8] = sh_mic;
        cfg_b[8*i +: 8] = sh_mic;
      end else begin
        cfg_a[8*i +: 8] = wreg[0][i];
        cfg_b[8*i +: 8] = wreg[1][i];
      end
    end
  end

  always_comb begin
    case (idx)
      4'd0:    rd_mux = line_st[acc_ch];
      4'd1:    rd_mux = cond_st[acc_ch];
      4'd2:    rd_mux = acc_ch ? vec_live : sh_vec;
      4'd3:    rd_mux = acc_ch ? 8'h00 : irq_pend;
      4'd4:    rd_mux = ext ? wreg[acc_ch][4] : 8'h00;
      4'd5:    rd_mux = ext ? wreg[acc_ch][5] : 8'h00;
      4'd8:    rd_mux = rx_byte[acc_ch];
      4'd9:    rd_mux = ext ? wreg[acc_ch][3] : 8'h00;
      4'd10:   rd_mux = clk_st[acc_ch];
      4'd11:   rd_mux = ext ? wreg[acc_ch][10] : 8'h00;
      4'd12, 4'd13, 4'd15: rd_mux = wreg[acc_ch][idx];
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rdata    <= '0;
      sh_vec   <= '0;
      sh_mic   <= '0;
      tx_load  <= '0;
      cmd_stb  <= '0;
      cmd_val  <= '0;
      chan_rst <= '0;
      dpll_stb <= '0;
      dpll_cmd <= '0;
      for (int c = 0; c < 2; c++) begin
        opt[c] <= '0;
        ptr[c] <= '0;
        for (int i = 0; i < 16; i++) wreg[c][i] <= '0;
      end
    end else begin
      tx_load  <= '0;
      cmd_stb  <= '0;
      dpll_stb <= '0;
      chan_rst <= rcmd;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (go) begin
        cnt <= CW'(RECOV);
        if (!acc_wr) begin
          rdata <= rd_mux;
        end else if (idx == 4'd0) begin
          ptr[acc_ch]     <= wdata[3:0];
          cmd_stb[acc_ch] <= 1'b1;
          cmd_val         <= wdata;
        end else begin
          case (idx)
            4'd2: sh_vec <= wdata;
            4'd7: begin
              if (wreg[acc_ch][15][0]) opt[acc_ch] <= wdata;
              else                     wreg[acc_ch][7] <= wdata;
            end
            4'd8: begin
              wreg[acc_ch][8] <= wdata;
              tx_load[acc_ch] <= 1'b1;
            end
            4'd9: sh_mic <= {2'b00, wdata[5:0]};
            4'd14: begin
              wreg[acc_ch][14] <= {3'b000, wdata[4:0]};
              if (wdata[7:5] != 3'b000) begin
                dpll_stb[acc_ch] <= 1'b1;
                dpll_cmd         <= wdata[7:5];
              end
            end
            default: wreg[acc_ch][idx] <= wdata;
          endcase
        end
        if (!acc_dp && idx != 4'd0) ptr[acc_ch] <= 4'd0;
      end
      for (int c = 0; c < 2; c++) begin
        if (rcmd[c]) begin
          opt[c] <= '0;
          ptr[c] <= '0;
          for (int i = 0; i < 16; i++) wreg[c][i] <= '0;
        end
      end
      if (rcmd == 2'b11) begin
        sh_vec <= '0;
        sh_mic <= '0;
      end
    end
  end
endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_en,
  input logic         busy,
  input logic [127:0] cfg_a,
  input logic [127:0] cfg_b,
  input logic [7:0]   opt_a,
  input logic [7:0]   opt_b,
  input logic [1:0]   tx_load,
  input logic [1:0]   cmd_stb,
  input logic [1:0]   chan_rst,
  input logic [1:0]   dpll_stb,
  input logic [2:0]   dpll_cmd
);
  // R10
  acc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !busy |=> busy);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && busy |=> $stable(cfg_a) && $stable(cfg_b) && $stable(opt_a) && $stable(opt_b));

  // R7
  hard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst == 2'b11 |-> cfg_a == '0 && cfg_b == '0 && opt_a == '0 && opt_b == '0);

  // R7
  chan_a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst[0] |-> opt_a == 8'h00);

  // R8
  dpll_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpll_stb != 2'b00 |-> dpll_cmd != 3'b000);

  // R2
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load != 2'b00 |-> $onehot0(tx_load) && cmd_stb == 2'b00 && dpll_stb == 2'b00);
endmodule

bind sio_regfile sio_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .busy(busy),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .opt_a(opt_a), .opt_b(opt_b),
  .tx_load(tx_load), .cmd_stb(cmd_stb), .chan_rst(chan_rst),
  .dpll_stb(dpll_stb), .dpll_cmd(dpll_cmd)
);

// File: tb/sio_regfile_tb.sv
`timescale 1ns/1ps
module sio_regfile_tb;
  localparam int RECOV = 4;

  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0, acc_ch = 0, acc_dp = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic busy;
  logic [1:0][7:0] line_st = {8'hB0, 8'hA0};
  logic [1:0][7:0] cond_st = {8'hB1, 8'hA1};
  logic [1:0][7:0] clk_st  = {8'hBA, 8'hA7};
  logic [1:0][7:0] rx_byte = {8'hD2, 8'hD1};
  logic [7:0] vec_live = 8'h5E, irq_pend = 8'h2A;
  logic [127:0] cfg_a, cfg_b;
  logic [7:0] opt_a, opt_b, cmd_val;
  logic [1:0] tx_load, cmd_stb, chan_rst, dpll_stb;
  logic [2:0] dpll_cmd;

  int errors = 0, checks = 0;
  logic [1:0] p_tx, p_cmd, p_rst, p_dpll;
  logic [2:0] p_code;
  logic [7:0] p_val, r;

  always #10 clk = ~clk;

  sio_regfile #(.RECOV(RECOV)) u_dut (.*);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sa(int i); return cfg_a[8*i +: 8]; endfunction
  function automatic logic [7:0] sb(int i); return cfg_b[8*i +: 8]; endfunction

  task automatic acc(logic ch, logic dp, logic wr, logic [7:0] v, output logic [7:0] rd);
    while (busy) @(negedge clk);
    acc_en = 1; acc_ch = ch; acc_dp = dp; acc_wr = wr; wdata = v;
    @(negedge clk);
    acc_en = 0;
    rd = rdata; p_tx = tx_load; p_cmd = cmd_stb; p_rst = chan_rst;
    p_dpll = dpll_stb; p_code = dpll_cmd; p_val = cmd_val;
  endtask

  task automatic cw(logic ch, logic [7:0] v); logic [7:0] d; acc(ch, 0, 1, v, d); endtask
  task automatic cr(logic ch, output logic [7:0] d); acc(ch, 0, 0, 8'h00, d); endtask
  task automatic rw(logic ch, logic [3:0] i, logic [7:0] v); cw(ch, {4'h0, i}); cw(ch, v); endtask
  task automatic rr(logic ch, logic [3:0] i, output logic [7:0] d); cw(ch, {4'h0, i}); cr(ch, d); endtask

  task automatic t_reset;
    chk("R11 cfg_a", cfg_a, 0); chk("R11 cfg_b", cfg_b, 0);
    chk("R11 busy", busy, 0);   chk("R11 rdata", rdata, 0);
    chk("R11 opt", {opt_a, opt_b}, 0);
  endtask

  task automatic t_pointer;
    cr(0, r); chk("R1 status at ptr0", r, 8'hA0);
    rw(0, 12, 8'h3C); chk("R1 slot12 written", sa(12), 8'h3C);
    rr(0, 12, r); chk("R1 read slot12", r, 8'h3C);
    cr(0, r); chk("R1 ptr back to zero", r, 8'hA0);
    rr(1, 1, r); chk("R1 cond status B", r, 8'hB1);
    rr(0, 10, r); chk("R1 clock status A", r, 8'hA7);
    cw(0, 8'h0D); cr(1, r); chk("R1 B ptr independent", r, 8'hB0);
    cw(0, 8'h77); chk("R1 A ptr kept across B", sa(13), 8'h77);
  endtask

  task automatic t_cmd;
    cw(0, 8'h10);
    chk("R12 cmd_stb", p_cmd, 2'b01); chk("R12 cmd_val", p_val, 8'h10);
    cr(0, r); chk("R12 ptr stays zero", r, 8'hA0);
  endtask

  task automatic t_busy;
    int n = 0;
    cw(0, 8'h0C);
    acc_en = 1; acc_wr = 1; acc_ch = 0; acc_dp = 0; wdata = 8'h99;
    @(negedge clk); acc_en = 0; n = 1;
    while (busy) begin n++; @(negedge clk); end
    chk("R10 busy length", n, RECOV);
    chk("R10 ignored write", sa(12), 8'h3C);
    cr(0, r); chk("R10 ptr still 12", r, 8'h3C);
  endtask

  task automatic t_data;
    acc(1, 1, 1, 8'h5A, r);
    chk("R2 tx_load", p_tx, 2'b10); chk("R2 slot8 B", sb(8), 8'h5A);
    cw(0, 8'h0C);
    acc(0, 1, 0, 8'h00, r); chk("R2 data read", r, 8'hD1);
    cr(0, r); chk("R2 ptr untouched", r, 8'h3C);
  endtask

  task automatic t_alt;
    rw(0, 7, 8'h7E); chk("R3 sync slot", sa(7), 8'h7E); chk("R3 opt untouched", opt_a, 8'h00);
    rw(0, 15, 8'h01); rw(0, 7, 8'h40);
    chk("R3 opt written", opt_a, 8'h40); chk("R3 sync kept", sa(7), 8'h7E);
  endtask

  task automatic t_ext;
    rw(0, 4, 8'h44); rw(0, 5, 8'h55); rw(0, 3, 8'h33); rw(0, 10, 8'hAA);
    rr(0, 4, r);  chk("R9 idx4", r, 8'h44);
    rr(0, 5, r);  chk("R9 idx5", r, 8'h55);
    rr(0, 9, r);  chk("R9 idx9", r, 8'h33);
    rr(0, 11, r); chk("R9 idx11", r, 8'hAA);
    rr(0, 15, r); chk("R9 idx15 echo", r, 8'h01);
    rw(1, 4, 8'h12); rr(1, 4, r); chk("R9 idx4 no ext", r, 8'h00);
    rw(1, 12, 8'h66); rr(1, 12, r); chk("R9 idx12 echo", r, 8'h66);
  endtask

  task automatic t_shared;
    rw(1, 2, 8'h9C);
    chk("R4 shared in A", sa(2), 8'h9C); chk("R4 shared in B", sb(2), 8'h9C);
    rr(0, 2, r); chk("R4 A reads vector", r, 8'h9C);
    rr(1, 2, r); chk("R6 B reads live vector", r, 8'h5E);
    rr(0, 3, r); chk("R5 pending on A", r, 8'h2A);
    rr(1, 3, r); chk("R5 zero on B", r, 8'h00);
  endtask

  task automatic t_dpll;
    rw(0, 14, 8'hE7);
    chk("R8 strobe", p_dpll, 2'b01); chk("R8 code", p_code, 3'b111);
    chk("R8 stored low bits", sa(14), 8'h07);
    rw(1, 14, 8'h03);
    chk("R8 no strobe", p_dpll, 2'b00); chk("R8 B stored", sb(14), 8'h03);
  endtask

  task automatic t_resets;
    rw(1, 9, 8'h0B);
    chk("R7 no reset", p_rst, 2'b00); chk("R7 shared mic", sa(9), 8'h0B);
    cw(1, 8'h0C);
    rw(0, 9, 8'h45);
    chk("R7 A pulse", p_rst, 2'b01); chk("R7 mic low bits", sa(9), 8'h05);
    chk("R7 A slot cleared", sa(12), 8'h00); chk("R7 A opt cleared", opt_a, 8'h00);
    chk("R7 shared kept", sa(2), 8'h9C); chk("R7 B kept", sb(4), 8'h12);
    cr(1, r); chk("R7 B ptr kept", r, 8'h66);
    cw(1, 8'h0C);
    rw(0, 9, 8'h80);
    chk("R7 B pulse", p_rst, 2'b10); chk("R7 B slot cleared", sb(4), 8'h00);
    cr(1, r); chk("R7 B ptr cleared", r, 8'hB0);
    rw(0, 4, 8'h21);
    rw(1, 9, 8'hC1);
    chk("R7 hard pulse", p_rst, 2'b11);
    chk("R7 hard A", cfg_a, 0); chk("R7 hard B", cfg_b, 0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_pointer(); t_cmd(); t_busy(); t_data(); t_alt();
    t_ext(); t_shared(); t_dpll(); t_resets();
    finish_run();
  end
endmodule